// File: doc/BRIEF.md
# Host Serial Control Port

This block is a slave serial port through which a host microcontroller programs a codec and reads back its state. The host raises an enable line, clocks bits with its own bit clock and picks the kind of transfer with two mode lines. Four kinds of transfer exist: a short extended-settings byte, 16-bit allocation or scale-factor words, a 16-bit operating-settings word and a 16-bit status read. All host pins are sampled through a two-stage synchronizer into the system clock domain. Input bits are captured on a detected rising edge of the host clock.

The block holds the extended settings and drives the DAC mute, attenuation and de-emphasis pins and a clock-ok hold flag from them. It also holds a filter-settings nibble and the operating-settings word. Each received allocation word leaves the block on a one-cycle write strobe. The status word is supplied by the rest of the device, and the block shifts a snapshot of it out to the host. A host write of operating settings is accepted only when the device reports itself ready, or when that write closes an allocation sequence.

Top module: `ctl_port`

## Requirements
- R1: After reset the outputs are as follows. mute_o is 1. atten_o, deemph_o and clk_hold_o are 0. filt_o is 4'b0001. cfg_o is 16'hC210: rate index 1100 in bits 15:12, sample-rate code 00 in bits 11:10, decode bit 9 = 1, channel-select bit 4 = 1, all other bits 0. sdata_oe_o and alloc_we_o are 0.
- R2: Mode 00 is a one-byte transfer. Wire bit i, with i from 0 to 7, is byte bit i. Bits 3:0 are data and bits 7:4 are the address. At address 0 the data bits set mute_o, atten_o, deemph_o and clk_hold_o, in that order from bit 0.
- R3: In mode 00, address 1 loads filt_o from the data bits. Addresses 2 to 15 change no output.
- R4: Mode 10 carries a 16-bit word. Wire bits 0 to 7 are word bits 8 to 15, and wire bits 8 to 15 are word bits 0 to 7, so each byte goes LSB first and the high byte goes first. When the word is accepted, cfg_o takes its value.
- R5: A mode-10 word is accepted only in two cases. Either status_i[9] was 1 when enable rose, or at least one allocation word arrived after the last accepted settings word. Otherwise cfg_o is unchanged.
- R6: Mode 11 snapshots status_i when enable rises. It drives sdata_o with sdata_oe_o = 1, in the bit order of R4. Each host clock rising edge advances to the next bit.
- R7: sdata_oe_o is 0 whenever enable is low and in every mode other than 11.
- R8: In mode 01, every 16 bits give one alloc_we_o pulse of one cycle, with alloc_data_o holding the word in the order of R4.
- R9: The mode lines are latched when enable rises. Changing them later in the transfer has no effect.
- R10: If enable falls before a unit is complete, nothing is written. The next transfer starts again at wire bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| en_i | input | 1 | host transfer enable |
| sclk_i | input | 1 | host bit clock |
| sdata_i | input | 1 | host serial data in |
| sdata_o | output | 1 | serial data out (status reads) |
| sdata_oe_o | output | 1 | output enable for the data line |
| mode_i | input | 2 | transfer type select |
| status_i | input | 16 | status word from the device, bit 9 = ready |
| mute_o | output | 1 | DAC mute pin |
| atten_o | output | 1 | DAC attenuation pin |
| deemph_o | output | 1 | DAC de-emphasis pin |
| clk_hold_o | output | 1 | clock-ok hold mode flag |
| filt_o | output | 4 | filter settings nibble |
| cfg_o | output | 16 | operating settings word |
| alloc_we_o | output | 1 | allocation word strobe |
| alloc_data_o | output | 16 | allocation word |

## Verification
The bench checks the wire order of the bytes by sending asymmetric patterns. A port that put the low byte first, or that shifted bits MSB first, would load visibly different settings and allocation words.

It also covers the readiness rule from both sides:
- a settings write while not ready, which must be dropped;
- the same write just after allocation words, which must land;
- one more such write, which must be dropped again. A design that never cleared the allocation flag would accept that last write.

Extended bytes aimed at unused addresses must leave every pin alone. The mode lines are changed in the middle of a transfer, which catches a design that decodes the live mode. A transfer is also cut short, to catch a bit counter that does not restart when enable drops.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int UNIT_W = 8;
  localparam int WORD_W = 2 * UNIT_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int NIB_W  = 4;
  localparam int READY_BIT = 9;

  localparam logic [WORD_W-1:0] CFG_RST  = 16'hC210;
  localparam logic [NIB_W-1:0]  EXT_RST  = 4'b0001;
  localparam logic [NIB_W-1:0]  FILT_RST = 4'b0001;

  typedef enum logic [1:0] {
    XF_EXT   = 2'b00,
    XF_ALLOC = 2'b01,
    XF_SET   = 2'b10,
    XF_STAT  = 2'b11
  } xfer_e;

  // wire bit count -> word bit: high byte first, each byte LSB first
  function automatic logic [CNT_W-1:0] wire_pos(input logic [CNT_W-1:0] c);
    return {~c[CNT_W-1], c[CNT_W-2:0]};
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter
  import ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sd_i,
  input  logic [1:0]        mode_i,
  output logic              start_o,
  output xfer_e             xfer_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              byte_we_o,
  output logic              word_we_o,
  output logic [WORD_W-1:0] word_o
);
  logic              en_q, sclk_q, sclk_rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q, word_nx;

  assign start_o   = en_i & ~en_q;
  assign sclk_rise = en_i & sclk_i & ~sclk_q;

  always_comb begin
    word_nx = shreg_q;
    word_nx[wire_pos(cnt_q)] = sd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      sclk_q    <= 1'b0;
      cnt_q     <= '0;
      shreg_q   <= '0;
      xfer_o    <= XF_EXT;
      byte_we_o <= 1'b0;
      word_we_o <= 1'b0;
      word_o    <= '0;
    end else begin
      en_q      <= en_i;
      sclk_q    <= sclk_i;
      byte_we_o <= sclk_rise && (cnt_q == CNT_W'(UNIT_W-1));
      word_we_o <= sclk_rise && (cnt_q == CNT_W'(WORD_W-1));
      if (start_o) xfer_o <= xfer_e'(mode_i);
      if (!en_i) cnt_q <= '0;
      else if (sclk_rise) begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= word_nx;
        word_o  <= word_nx;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R10
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  input  xfer_e             xfer_i,
  input  logic              byte_we_i,
  input  logic              word_we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  ext_o,
  output logic [NIB_W-1:0]  filt_o,
  output logic [WORD_W-1:0] cfg_o,
  output logic              alloc_we_o,
  output logic [WORD_W-1:0] alloc_data_o
);
  localparam logic [NIB_W-1:0] ADDR_DAC  = 4'd0;
  localparam logic [NIB_W-1:0] ADDR_FILT = 4'd1;

  logic [NIB_W-1:0] ext_dat, ext_adr;
  logic             ext_we, filt_we, set_we, alloc_hit;
  logic             alloc_open_q, set_ok_q;

  assign ext_dat   = word_i[WORD_W-UNIT_W +: NIB_W];
  assign ext_adr   = word_i[WORD_W-NIB_W +: NIB_W];
  assign ext_we    = byte_we_i && (xfer_i == XF_EXT) && (ext_adr == ADDR_DAC);
  assign filt_we   = byte_we_i && (xfer_i == XF_EXT) && (ext_adr == ADDR_FILT);
  assign set_we    = word_we_i && (xfer_i == XF_SET) && set_ok_q;
  assign alloc_hit = word_we_i && (xfer_i == XF_ALLOC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_o        <= EXT_RST;
      filt_o       <= FILT_RST;
      cfg_o        <= CFG_RST;
      alloc_we_o   <= 1'b0;
      alloc_data_o <= '0;
      alloc_open_q <= 1'b0;
      set_ok_q     <= 1'b0;
    end else begin
      alloc_we_o <= alloc_hit;
      if (alloc_hit) alloc_data_o <= word_i;
      if (start_i) set_ok_q <= ready_i | alloc_open_q;
      if (ext_we)  ext_o  <= ext_dat;
      if (filt_we) filt_o <= ext_dat;
      if (set_we)  cfg_o  <= word_i;
      if (alloc_hit)   alloc_open_q <= 1'b1;
      else if (set_we) alloc_open_q <= 1'b0;
    end
  end

  // R2
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_we |=> $stable(ext_o));
  // R4
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_we |=> $stable(cfg_o));
  // R8
  alloc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_we_o |=> !alloc_we_o);
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import ctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        sclk_i,
  input  logic        sdata_i,
  output logic        sdata_o,
  output logic        sdata_oe_o,
  input  logic [1:0]  mode_i,
  input  logic [15:0] status_i,
  output logic        mute_o,
  output logic        atten_o,
  output logic        deemph_o,
  output logic        clk_hold_o,
  output logic [3:0]  filt_o,
  output logic [15:0] cfg_o,
  output logic        alloc_we_o,
  output logic [15:0] alloc_data_o
);
  logic [4:0]        pins_s;
  logic              en_s, sclk_s, sd_s;
  logic [1:0]        mode_s;
  logic              start, byte_we, word_we;
  xfer_e             xfer;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word, rd_q;
  logic [NIB_W-1:0]  ext;
  logic              oe_q;

  ctl_sync #(.W(5), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mode_i, sdata_i, sclk_i, en_i}),
    .q_o   (pins_s)
  );
  assign {mode_s, sd_s, sclk_s, en_s} = pins_s;

  ctl_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_s),
    .sclk_i   (sclk_s),
    .sd_i     (sd_s),
    .mode_i   (mode_s),
    .start_o  (start),
    .xfer_o   (xfer),
    .cnt_o    (cnt),
    .byte_we_o(byte_we),
    .word_we_o(word_we),
    .word_o   (word)
  );

  ctl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .ready_i     (status_i[READY_BIT]),
    .xfer_i      (xfer),
    .byte_we_i   (byte_we),
    .word_we_i   (word_we),
    .word_i      (word),
    .ext_o       (ext),
    .filt_o      (filt_o),
    .cfg_o       (cfg_o),
    .alloc_we_o  (alloc_we_o),
    .alloc_data_o(alloc_data_o)
  );

  // status snapshot and line drive for reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      oe_q <= 1'b0;
    end else if (!en_s) begin
      oe_q <= 1'b0;
    end else if (start) begin
      rd_q <= status_i;
      oe_q <= (xfer_e'(mode_s) == XF_STAT);
    end
  end

  assign sdata_oe_o = oe_q;
  assign sdata_o    = oe_q & rd_q[wire_pos(cnt)];
  assign mute_o     = ext[0];
  assign atten_o    = ext[1];
  assign deemph_o   = ext[2];
  assign clk_hold_o = ext[3];

  // R7
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !sdata_oe_o);
  // R6
  oe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && !start) |-> (xfer == XF_STAT));
endmodule

// File: tb/tb_ctl_port.sv
module tb_ctl_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] status = 16'h0000;
  logic        sdo, sdo_oe, mute, atten, deemph, hold, awe;
  logic [3:0]  filt;
  logic [15:0] cfg, adata;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  ctl_port dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sclk_i(sclk), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe_o(sdo_oe), .mode_i(mode), .status_i(status),
    .mute_o(mute), .atten_o(atten), .deemph_o(deemph), .clk_hold_o(hold),
    .filt_o(filt), .cfg_o(cfg), .alloc_we_o(awe), .alloc_data_o(adata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int pos(input int i);
    return (i < 8) ? i + 8 : i - 8;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one transfer; mode switches to m2 after enable rises
  task automatic xfer(input logic [1:0] m, input logic [1:0] m2, input int nbits,
                      input logic [15:0] w, output logic [15:0] rd, output logic oe_seen);
    rd = '0;
    oe_seen = 1'b1;
    mode = m;
    wait_clk(4);
    en = 1'b1;
    wait_clk(6);
    mode = m2;
    for (int i = 0; i < nbits; i++) begin
      sdi = w[pos(i)];
      wait_clk(8);
      rd[pos(i)] = sdo;
      oe_seen &= sdo_oe;
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
    wait_clk(4);
    en = 1'b0;
    wait_clk(8);
  endtask

  task automatic send(input logic [1:0] m, input int nbits, input logic [15:0] w);
    logic [15:0] r;
    logic o;
    if (m == 2'b01) exp_q.push_back(w);
    xfer(m, m, nbits, w, r, o);
  endtask

  // scoreboard monitor for allocation strobes
  always @(negedge clk) begin
    if (rst_n && awe) begin
      if (exp_q.size() == 0) check("R8 unexpected strobe", adata, 16'hxxxx);
      else check("R8 alloc word", adata, exp_q.pop_front());
    end
  end

  initial begin
    wait_clk(200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    logic o;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R1
    check("R1 dac pins", {12'd0, hold, deemph, atten, mute}, 16'h0001);
    check("R1 filt", {12'd0, filt}, 16'h0001);
    check("R1 cfg", cfg, 16'hC210);
    check("R1 oe/we", {14'd0, sdo_oe, awe}, 16'h0000);
    // R2: addr 0, data 1010
    send(2'b00, 8, {8'h0A, 8'h00});
    check("R2 dac pins", {12'd0, hold, deemph, atten, mute}, 16'h000A);
    // R3: addr 1 -> filt, addr 5 ignored
    send(2'b00, 8, {8'h10, 8'h00});
    check("R3 filt load", {12'd0, filt}, 16'h0000);
    check("R3 pins kept", {12'd0, hold, deemph, atten, mute}, 16'h000A);
    send(2'b00, 8, {8'h5F, 8'h00});
    check("R3 unused addr pins", {12'd0, hold, deemph, atten, mute}, 16'h000A);
    check("R3 unused addr filt", {12'd0, filt}, 16'h0000);
    // R5: not ready -> rejected
    status = 16'h0000;
    send(2'b10, 16, 16'h1234);
    check("R5 reject not ready", cfg, 16'hC210);
    // R4: ready -> accepted
    status = 16'h0200;
    send(2'b10, 16, 16'h8E51);
    check("R4 settings word", cfg, 16'h8E51);
    // R6/R7: status read
    status = 16'hA5C3;
    xfer(2'b11, 2'b11, 16, 16'h0000, r, o);
    check("R6 read data", r, 16'hA5C3);
    check("R6 oe during read", {15'd0, o}, 16'h0001);
    check("R7 oe released", {15'd0, sdo_oe}, 16'h0000);
    check("R7 no write on read", cfg, 16'h8E51);
    // R8 + R5 closing sequence
    status = 16'h0000;
    send(2'b01, 16, 16'h1357);
    send(2'b01, 16, 16'hFEDC);
    send(2'b10, 16, 16'h4321);
    check("R5 close after alloc", cfg, 16'h4321);
    send(2'b10, 16, 16'h1111);
    check("R5 reject after close", cfg, 16'h4321);
    check("R8 queue drained", 16'(exp_q.size()), 16'h0000);
    // R10: aborted transfer
    status = 16'h0200;
    send(2'b10, 5, 16'hFFFF);
    check("R10 aborted", cfg, 16'h4321);
    send(2'b10, 16, 16'h0F0F);
    check("R10 restart", cfg, 16'h0F0F);
    // R9: mode changes mid transfer
    xfer(2'b00, 2'b11, 8, {8'h01, 8'h00}, r, o);
    check("R9 latched mode pins", {12'd0, hold, deemph, atten, mute}, 16'h0001);
    check("R9 no read drive", {15'd0, o}, 16'h0000);
    check("R7 oe idle", {15'd0, sdo_oe}, 16'h0000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule